// File: doc/BRIEF.md
# SAR ADC Conversion and Readout Sequencer

This block sits on the host side of a successive-approximation converter. It handles one sample request from start to finish. A single-cycle start pulse, latched together with a link mode, a turbo flag and a device count, begins a request. The block then drives the convert strobe, waits out the conversion time, and clocks the result in serially over an SPI-style link. The result leaves on a valid/ready stream. There are three link modes:
- a dedicated convert pin with its own active-low select;
- one line that serves as both convert and select;
- a daisy chain in which one burst reads several converters.

Results are 14, 16 or 18 bits wide. Each result is widened to a 16-bit word, or to a 32-bit word when it is wider than 16 bits, by zero or sign extension. Conversion, turbo and quiet times are given in nanoseconds. They become clock counts rounded up, so every minimum time is met. The output stream obeys back-pressure. While `out_valid_o` is high and `out_ready_i` is low, the word, the device index and the last flag hold still. The next word is not produced until the current one has been accepted. The block stays busy until the last word of a request is accepted.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset `busy_o`, `out_valid_o`, `cnv_o` and `sclk_o` are all low.
- R2: In mode 0 (dedicated pin, `mode_i`=0), `cnv_o` rises at the start of a request. It stays high through the conversion wait and every serial clock pulse. `sel_o` is low only while bits are shifted. `cnv_o` is low once the result is presented.
- R3: The first rising edge of `sclk_o` comes no earlier than the conversion time after the convert edge. With `turbo_i` set, the turbo time is used in modes 0 and 1. Otherwise the normal time is used. Both times are rounded up to whole clock cycles.
- R4: In mode 1 (shared line, `mode_i`=1), `sel_o` is driven low for at least the quiet time before the rising edge that starts the conversion. It then stays high through the conversion wait and goes low again while the data is shifted in.
- R5: In mode 2 (chain, `mode_i`=2), `sel_o` is active high and stays high from the convert edge until the last word. The normal conversion time is always used, whatever `turbo_i` is. `ndev_i` words are returned: `out_dev_o` counts 0 upward and `out_last_o` marks the final word. An `ndev_i` of 0 counts as 1. In modes 0 and 1 the single word always has `out_last_o` high.
- R6: `sclk_o` idles low. Each word is RES_BITS bits, sampled from `sdi_i` at the rising edges of `sclk_o`, most significant bit first.
- R7: A result is widened to OUT_W bits: 32 when RES_BITS > 16, otherwise 16. It is sign-extended from bit RES_BITS-1 when SIGNED_OUT=1 and zero-extended otherwise.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o`, `out_data_o`, `out_dev_o` and `out_last_o` hold their values.
- R9: A start pulse is ignored while `busy_o` is high, and also when `mode_i`=3. Such a pulse produces no extra word and no strobe activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse |
| mode_i | input | 2 | Link mode: 0 dedicated, 1 shared, 2 chain, 3 reserved |
| turbo_i | input | 1 | Use the turbo conversion time (modes 0 and 1) |
| ndev_i | input | $clog2(MAX_DEV+1) | Devices in the chain |
| busy_o | output | 1 | Request in progress |
| cnv_o | output | 1 | Dedicated convert pin |
| sel_o | output | 1 | Select line, driven at its wire level |
| sclk_o | output | 1 | Serial clock |
| sdi_i | input | 1 | Serial data from the converter |
| out_valid_o | output | 1 | Result word valid |
| out_ready_i | input | 1 | Consumer accepts the word |
| out_data_o | output | OUT_W | Widened result |
| out_dev_o | output | $clog2(MAX_DEV+1) | Index of the device the word belongs to |
| out_last_o | output | 1 | Final word of the request |

## Verification
The bench measures, for each request, how many cycles pass between the convert edge and the first serial clock rise. It checks both a lower and an upper bound. A design that clocked early, used the turbo time in chain mode, or ignored turbo would fall outside the window. Words with the top bit set and clear are sent through both a signed 18-bit instance and an unsigned 14-bit instance. Wrong extension or bit order would show up as a data mismatch. Back-pressure arrives in pseudo-random bursts, a second start is fired in the middle of a request, and a reserved mode is tried. A design that dropped a held word, let it change, or produced extra words would leave the scoreboard short or surplus.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    LINK_DED    = 2'd0,
    LINK_SHARED = 2'd1,
    LINK_CHAIN  = 2'd2,
    LINK_RSVD   = 2'd3
  } link_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QUIET,
    ST_CONV,
    ST_READ,
    ST_SHIFT,
    ST_OUT
  } seq_state_e;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sar_wait_timer.sv
module sar_wait_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R3

endmodule

// File: rtl/sar_serial_rx.sv
module sar_serial_rx #(
  parameter int RES_BITS  = 18,
  parameter int SCLK_HALF = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic                sdi,
  output logic                sclk,
  output logic [RES_BITS-1:0] word,
  output logic                done
);

  localparam int HCW = $clog2(SCLK_HALF + 1);
  localparam int BCW = $clog2(RES_BITS + 1);

  logic           active;
  logic [HCW-1:0] hcnt;
  logic [BCW-1:0] bits_left;
  logic [RES_BITS-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      sclk      <= 1'b0;
      hcnt      <= '0;
      bits_left <= '0;
      shreg     <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !active) begin
        active    <= 1'b1;
        sclk      <= 1'b0;
        hcnt      <= HCW'(SCLK_HALF - 1);
        bits_left <= BCW'(RES_BITS);
      end else if (active) begin
        if (hcnt != '0) begin
          hcnt <= hcnt - 1'b1;
        end else begin
          hcnt <= HCW'(SCLK_HALF - 1);
          if (!sclk) begin
            sclk      <= 1'b1;
            shreg     <= {shreg[RES_BITS-2:0], sdi};
            bits_left <= bits_left - 1'b1;
          end else begin
            sclk <= 1'b0;
            if (bits_left == '0) begin
              active <= 1'b0;
              done   <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign word = shreg;

  AST_RX_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> (bits_left == '0 && !sclk)); // R6

endmodule

// File: rtl/sar_result_fmt.sv
module sar_result_fmt #(
  parameter int RES_BITS   = 18,
  parameter int OUT_W      = 32,
  parameter bit SIGNED_OUT = 1'b1
) (
  input  logic [RES_BITS-1:0] raw,
  output logic [OUT_W-1:0]    wide
);

  generate
    if (OUT_W == RES_BITS) begin : g_same
      assign wide = raw;
    end else if (SIGNED_OUT) begin : g_sext
      assign wide = {{(OUT_W-RES_BITS){raw[RES_BITS-1]}}, raw};
    end else begin : g_zext
      assign wide = {{(OUT_W-RES_BITS){1'b0}}, raw};
    end
  endgenerate

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
#(
  parameter int RES_BITS   = 18,
  parameter bit SIGNED_OUT = 1'b1,
  parameter int MAX_DEV    = 32,
  parameter int CLK_NS     = 20,
  parameter int CONV_NS    = 420,
  parameter int TURBO_NS   = 320,
  parameter int QUIET_NS   = 20,
  parameter int SCLK_HALF  = 2,
  localparam int OUT_W     = (RES_BITS > 16) ? 32 : 16,
  localparam int DEVW      = $clog2(MAX_DEV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic             turbo_i,
  input  logic [DEVW-1:0]  ndev_i,
  output logic             busy_o,
  output logic             cnv_o,
  output logic             sel_o,
  output logic             sclk_o,
  input  logic             sdi_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [OUT_W-1:0] out_data_o,
  output logic [DEVW-1:0]  out_dev_o,
  output logic             out_last_o
);

  localparam int CONV_CYC  = ns_to_cyc(CONV_NS, CLK_NS);
  localparam int TURBO_CYC = ns_to_cyc(TURBO_NS, CLK_NS);
  localparam int QUIET_CYC = ns_to_cyc(QUIET_NS, CLK_NS);
  localparam int TW        = $clog2(max3(CONV_CYC, TURBO_CYC, QUIET_CYC) + 1);

  seq_state_e state, state_nx;
  link_mode_e lat_mode;
  logic       lat_turbo;
  logic [DEVW-1:0] lat_last, dev_idx;

  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  logic          rx_go, rx_done;
  logic [RES_BITS-1:0] rx_word;

  link_mode_e mode_in;
  logic       start_ok;
  logic [TW-1:0] conv_len_in, conv_len_lat;

  assign mode_in  = link_mode_e'(mode_i);
  assign start_ok = start_i && (mode_in != LINK_RSVD);

  assign conv_len_in  = (turbo_i && mode_in != LINK_CHAIN) ? TW'(TURBO_CYC) : TW'(CONV_CYC);
  assign conv_len_lat = (lat_turbo && lat_mode != LINK_CHAIN) ? TW'(TURBO_CYC) : TW'(CONV_CYC);

  // Sequencer next state and timer loads
  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    rx_go    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start_ok) begin
          tmr_load = 1'b1;
          if (mode_in == LINK_SHARED) begin
            state_nx = ST_QUIET;
            tmr_val  = TW'(QUIET_CYC);
          end else begin
            state_nx = ST_CONV;
            tmr_val  = conv_len_in;
          end
        end
      end
      ST_QUIET: begin
        if (tmr_expired) begin
          state_nx = ST_CONV;
          tmr_load = 1'b1;
          tmr_val  = conv_len_lat;
        end
      end
      ST_CONV: begin
        if (tmr_expired) state_nx = ST_READ;
      end
      ST_READ: begin
        rx_go    = 1'b1;
        state_nx = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (rx_done) state_nx = ST_OUT;
      end
      ST_OUT: begin
        if (out_ready_i) begin
          if (lat_mode == LINK_CHAIN && dev_idx != lat_last) state_nx = ST_READ;
          else                                               state_nx = ST_IDLE;
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lat_mode  <= LINK_DED;
      lat_turbo <= 1'b0;
      lat_last  <= '0;
      dev_idx   <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_IDLE && start_ok) begin
        lat_mode  <= mode_in;
        lat_turbo <= turbo_i;
        dev_idx   <= '0;
        if (mode_in != LINK_CHAIN || ndev_i == '0) lat_last <= '0;
        else if (ndev_i > DEVW'(MAX_DEV))          lat_last <= DEVW'(MAX_DEV - 1);
        else                                       lat_last <= ndev_i - 1'b1;
      end else if (state == ST_OUT && out_ready_i && state_nx == ST_READ) begin
        dev_idx <= dev_idx + 1'b1;
      end
    end
  end

  // Pin levels per state and mode
  always_comb begin
    cnv_o = 1'b0;
    sel_o = 1'b1;
    unique case (state)
      ST_IDLE:  sel_o = (mode_in != LINK_CHAIN);
      ST_QUIET: sel_o = 1'b0;
      ST_CONV: begin
        sel_o = 1'b1;
        cnv_o = (lat_mode == LINK_DED);
      end
      ST_READ, ST_SHIFT: begin
        sel_o = (lat_mode == LINK_CHAIN);
        cnv_o = (lat_mode == LINK_DED);
      end
      ST_OUT:   sel_o = 1'b1;
      default:  sel_o = 1'b1;
    endcase
  end

  sar_wait_timer #(.CW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sar_serial_rx #(.RES_BITS(RES_BITS), .SCLK_HALF(SCLK_HALF)) u_rx (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (rx_go),
    .sdi  (sdi_i),
    .sclk (sclk_o),
    .word (rx_word),
    .done (rx_done)
  );

  sar_result_fmt #(.RES_BITS(RES_BITS), .OUT_W(OUT_W), .SIGNED_OUT(SIGNED_OUT)) u_fmt (
    .raw  (rx_word),
    .wide (out_data_o)
  );

  assign busy_o      = (state != ST_IDLE);
  assign out_valid_o = (state == ST_OUT);
  assign out_dev_o   = dev_idx;
  assign out_last_o  = (lat_mode != LINK_CHAIN) || (dev_idx == lat_last);

  AST_READ_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ) |-> ($past(state) == ST_CONV || $past(state) == ST_OUT)); // R3

  AST_DED_CNV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && lat_mode == LINK_DED) |-> (cnv_o && !sel_o)); // R2

  AST_QUIET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV && $past(state) == ST_IDLE) |-> (lat_mode != LINK_SHARED)); // R4

  AST_CHAIN_SEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && lat_mode == LINK_CHAIN) |-> sel_o); // R5

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) &&
                                       $stable(out_dev_o) && $stable(out_last_o))); // R8

  AST_BUSY_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(lat_mode)); // R9

endmodule

// File: tb/sar_adc_ctrl_tb_top.sv
module sar_adc_model #(
  parameter int W    = 18,
  parameter int NDEV = 4
) (
  input  logic            clk,
  input  logic            conv_line,
  input  logic            sclk,
  input  logic [W*NDEV-1:0] load_val,
  output logic            sdo
);
  logic [W*NDEV-1:0] sh = '0;
  logic conv_q = 1'b0;
  logic sclk_q = 1'b0;
  always @(negedge clk) begin
    if (conv_line && !conv_q)  sh <= load_val;
    else if (!sclk && sclk_q)  sh <= {sh[W*NDEV-2:0], 1'b0};
    conv_q <= conv_line;
    sclk_q <= sclk;
  end
  assign sdo = sh[W*NDEV-1];
endmodule

module sar_adc_ctrl_tb_top;
  localparam int RB = 18;
  localparam int OW = 32;
  localparam int DW = 6;
  localparam int ND = 4;
  localparam int CONV_C  = (420 + 19) / 20;
  localparam int TURBO_C = (320 + 19) / 20;
  localparam int QUIET_C = 1;
  localparam int HALF    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic start = 1'b0, turbo = 1'b0, out_ready = 1'b1;
  logic [1:0] mode = 2'd0;
  logic [DW-1:0] ndev = '0;
  logic busy, cnv, sel, sclk, sdi, out_valid, out_last;
  logic [OW-1:0] out_data;
  logic [DW-1:0] out_dev;
  logic [RB*ND-1:0] pat = '0;

  int n_checks = 0, n_errors = 0;
  int cur_mode = 0;
  bit cur_turbo = 0;
  logic conv_line;

  sar_adc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .turbo_i(turbo),
    .ndev_i(ndev), .busy_o(busy), .cnv_o(cnv), .sel_o(sel), .sclk_o(sclk),
    .sdi_i(sdi), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_data_o(out_data), .out_dev_o(out_dev), .out_last_o(out_last));

  assign conv_line = (cur_mode == 0) ? cnv : sel;
  sar_adc_model #(.W(RB), .NDEV(ND)) u_model (
    .clk(clk), .conv_line(conv_line), .sclk(sclk), .load_val(pat), .sdo(sdi));

  // Unsigned 14-bit instance
  logic u_start = 1'b0, u_busy, u_cnv, u_sel, u_sclk, u_sdi, u_valid, u_last;
  logic [15:0] u_data;
  logic [DW-1:0] u_dev;
  logic [13:0] u_pat = '0;
  sar_adc_ctrl #(.RES_BITS(14), .SIGNED_OUT(1'b0)) dut_u_i (
    .clk(clk), .rst_n(rst_n), .start_i(u_start), .mode_i(2'd0), .turbo_i(1'b0),
    .ndev_i(6'd1), .busy_o(u_busy), .cnv_o(u_cnv), .sel_o(u_sel), .sclk_o(u_sclk),
    .sdi_i(u_sdi), .out_valid_o(u_valid), .out_ready_i(1'b1),
    .out_data_o(u_data), .out_dev_o(u_dev), .out_last_o(u_last));
  sar_adc_model #(.W(14), .NDEV(1)) u_model_u (
    .clk(clk), .conv_line(u_cnv), .sclk(u_sclk), .load_val(u_pat), .sdo(u_sdi));

  logic [OW-1:0] exp_data_q[$];
  int            exp_dev_q[$];
  bit            exp_last_q[$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Back-pressure pattern
  initial begin
    logic [7:0] lf = 8'hA5;
    forever begin
      @(posedge clk);
      #1;
      out_ready = lf[0] | lf[2];
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end
  end

  // Scoreboard monitor and stall check
  bit held_f = 0;
  logic [OW-1:0] held_d;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held_f) begin
        check(out_valid && out_data == held_d, "R8 hold under stall", out_data, held_d);
        held_f = 0;
      end
      if (out_valid && out_ready) begin
        if (exp_data_q.size() == 0) begin
          check(0, "R9 unexpected word", out_data, 0);
        end else begin
          logic [OW-1:0] ed;
          int edv;
          bit el;
          ed = exp_data_q.pop_front();
          edv = exp_dev_q.pop_front();
          el = exp_last_q.pop_front();
          check(out_data == ed, "R6/R7 data", out_data, ed);
          check(int'(out_dev) == edv, "R5 device index", out_dev, edv);
          check(out_last == el, "R5 last flag", out_last, el);
        end
      end else if (out_valid) begin
        held_f = 1;
        held_d = out_data;
      end
    end
  end

  // Timing monitor: convert-to-first-clock window, quiet time, pin levels
  int since_conv = 0, low_cnt = 0;
  bit armed = 0;
  logic conv_q = 0, sclk_q = 0, sel_q = 1;
  always @(negedge clk) begin
    if (rst_n) begin
      int lo;
      lo = (cur_turbo && cur_mode != 2) ? TURBO_C : CONV_C;
      if (conv_line && !conv_q && busy) begin
        since_conv = 0;
        armed = 1;
      end else begin
        since_conv++;
      end
      if (sclk && !sclk_q && armed) begin
        armed = 0;
        check(since_conv >= lo && since_conv <= lo + HALF + 3,
              "R3 convert-to-clock window", since_conv, lo);
      end
      if (cur_mode == 1 && busy && sel && !sel_q && !sclk)
        check(low_cnt >= QUIET_C, "R4 quiet low time", low_cnt, QUIET_C);
      low_cnt = sel ? 0 : low_cnt + 1;
      if (sclk && !sclk_q) begin
        if (cur_mode == 0) check(cnv && !sel, "R2 cnv high and select low while clocking", {cnv, sel}, 2'b10);
        if (cur_mode == 1) check(!sel && !cnv, "R4 select low during readout", sel, 0);
        if (cur_mode == 2) check(sel, "R5 select high in chain burst", sel, 1);
      end
      if (out_valid && cur_mode == 0) check(!cnv, "R2 cnv low at result", cnv, 0);
      conv_q = conv_line;
      sclk_q = sclk;
      sel_q = sel;
    end
  end

  task automatic run_txn(input int md, input bit tb_turbo, input int nd,
                         input logic [RB*ND-1:0] p, input bit extra);
    int nd_eff;
    nd_eff = (md != 2 || nd == 0) ? 1 : nd;
    cur_mode = md;
    cur_turbo = tb_turbo;
    pat = p;
    for (int i = 0; i < nd_eff; i++) begin
      logic [RB-1:0] w;
      w = p[RB*ND-1-RB*i -: RB];
      exp_data_q.push_back({{(OW-RB){w[RB-1]}}, w});
      exp_dev_q.push_back(i);
      exp_last_q.push_back(i == nd_eff - 1);
    end
    @(posedge clk); #1;
    mode = md[1:0]; turbo = tb_turbo; ndev = DW'(nd); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (extra) begin
      repeat (10) @(posedge clk);
      #1; start = 1'b1; mode = 2'd1;
      @(posedge clk); #1; start = 1'b0; mode = md[1:0];
    end
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      if (!busy) break;
    end
    check(!busy, "R8 request completes", busy, 0);
    repeat (4) @(negedge clk);
    check(exp_data_q.size() == 0, "R5 all words delivered", exp_data_q.size(), 0);
    exp_data_q.delete(); exp_dev_q.delete(); exp_last_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!busy && !out_valid && !cnv && !sclk, "R1 reset state",
          {busy, out_valid, cnv, sclk}, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(!busy && !out_valid && !cnv && !sclk, "R1 idle after reset",
          {busy, out_valid, cnv, sclk}, 0);

    // R2 / R3 / R6 / R7: dedicated pin, normal and turbo, positive and negative words
    run_txn(0, 0, 1, {18'h1F0F0, 54'h0}, 0);
    run_txn(0, 1, 1, {18'h20000, 54'h0}, 0);
    run_txn(0, 0, 1, {18'h3FFFF, 54'h0}, 1);   // R9 start while busy
    // R4: shared line
    run_txn(1, 0, 1, {18'h2ABCD, 54'h0}, 0);
    run_txn(1, 1, 1, {18'h00001, 54'h0}, 0);
    // R5: chain, turbo ignored, ndev 0 counts as 1
    run_txn(2, 0, 3, {18'h12345, 18'h3FFFE, 18'h00F0F, 18'h0}, 0);
    run_txn(2, 1, 4, {18'h20001, 18'h1FFFF, 18'h00000, 18'h35555}, 0);
    run_txn(2, 0, 0, {18'h2AAAA, 54'h0}, 0);

    // R9: reserved mode ignored
    cur_mode = 3;
    @(posedge clk); #1; mode = 2'd3; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    repeat (10) @(negedge clk);
    check(!busy && !out_valid && !sclk, "R9 reserved mode ignored",
          {busy, out_valid, sclk}, 0);
    mode = 2'd0; cur_mode = 0;

    // R7: unsigned 14-bit zero extension
    u_pat = 14'h2ABC;
    @(posedge clk); #1; u_start = 1'b1;
    @(posedge clk); #1; u_start = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (u_valid) break;
    end
    check(u_valid && u_data == 16'h2ABC && u_last, "R7 unsigned zero extension", u_data, 16'h2ABC);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule